// File: doc/BRIEF.md
# Burst Memory Access Sequencer

This block turns a single transfer request into a train of bursts on a word-addressed memory controller port that supports bursts. A request names a direction, a first word address and a word count. For a write, the block takes words from a ready/valid input stream and hands them to the controller as write bursts. For a read, it issues read bursts and passes every returned word straight to an output stream. A `done` level tells the requester when the whole range has been moved.

Returned read words cannot be held back. For that reason a read burst is only issued while the downstream buffer signals room for a full maximum-size burst. An internal credit counter also caps the number of words still in flight at `MAX_OUT * MAX_BURST`. The downstream buffer should therefore raise its almost-full flag with a margin of 8 plus `MAX_OUT * MAX_BURST` words.

The controller is an enumerated state machine with six states:
- `ST_IDLE` holds `done` high. A valid request moves it to `ST_WR_HEAD` or to `ST_RD_ISSUE`.
- `ST_WR_HEAD` presents the first beat of a write burst. If the first beat is accepted and the burst has more beats, it moves to `ST_WR_BODY`. After a one-beat burst it stays in `ST_WR_HEAD`, or goes to `ST_IDLE` when no words remain.
- `ST_WR_BODY` moves the remaining beats. After the last beat it returns to `ST_WR_HEAD`, or goes to `ST_IDLE` when no words remain.
- `ST_RD_ISSUE` offers a read command when room and credit allow. If the controller stalls the command, it moves to `ST_RD_HOLD`.
- `ST_RD_HOLD` keeps that command asserted until it is accepted. After the last command is accepted, either read state moves to `ST_RD_DRAIN`.
- `ST_RD_DRAIN` waits until every outstanding word has returned, then goes to `ST_IDLE`.

Top module: `mem_burst_seq`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `done` is 1 and neither `mem_write` nor `mem_read` is asserted.
- R2: While `done` is 1, a one-cycle `req_en` with a nonzero `req_count` samples `req_write` (1 = write, 0 = read), `req_addr` and `req_count`. `done` is 0 in the cycle after that pulse.
- R3: `done` returns to 1 only after every requested word has been moved. It then stays at 1 and no command is driven until the next request.
- R4: Each burst has length min(`MAX_BURST`, words left). The first burst starts at `req_addr`, and each later burst starts at the previous start plus the previous length. In total, exactly `req_count` words are moved.
- R5: `mem_write` is asserted only while `wr_in_valid` is 1. An input word is taken (`wr_in_valid` and `wr_in_ready` both 1) only in a cycle where `mem_waitreq` is 0 and `mem_write` is 1. The word is carried unchanged and in order to `mem_wdata` at consecutive addresses.
- R6: A new read command is only raised while `rd_out_ready` is 1. Words requested but not yet returned never exceed `MAX_OUT * MAX_BURST`.
- R7: Every returned word (`mem_rdvalid` = 1) appears on `rd_out_valid`/`rd_out_data` in the same cycle, in return order.
- R8: A `req_en` pulse while `done` is 0 is ignored: the running access continues unchanged and no other access follows it.
- R9: A `req_en` pulse with `req_count` = 0 is ignored: `done` stays 1 and no command is driven.
- R10: A read command stalled by `mem_waitreq` stays asserted, with the same `mem_addr` and `mem_burst_len`, until it is accepted.
- R11: `mem_burst_begin` is 1 only together with `mem_read`, or with the first beat of a write burst. A burst length is never 0 and never above `MAX_BURST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_en | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | First word address |
| req_count | input | CNT_W | Number of words |
| done | output | 1 | High when idle and after an access completes |
| wr_in_valid | input | 1 | Write stream word valid |
| wr_in_data | input | DATA_W | Write stream word |
| wr_in_ready | output | 1 | Write stream word taken when high with valid |
| rd_out_valid | output | 1 | Read stream word valid (no back-pressure) |
| rd_out_data | output | DATA_W | Read stream word |
| rd_out_ready | input | 1 | Downstream has room for a full burst |
| mem_addr | output | ADDR_W | Burst start address |
| mem_burst_len | output | LEN_W | Burst length in words |
| mem_burst_begin | output | 1 | Marks a read command or the first write beat |
| mem_write | output | 1 | Write beat request |
| mem_read | output | 1 | Read command request |
| mem_wdata | output | DATA_W | Write beat data |
| mem_waitreq | input | 1 | Controller stall |
| mem_rdvalid | input | 1 | Returned read word valid |
| mem_rdata | input | DATA_W | Returned read word |

## Verification
The checks assume that the controller returns exactly as many words as it accepted in read bursts, and never returns a word that was not requested. They also assume that reset is applied from time zero. The bench's controller model keeps both promises: it queues one return entry per accepted word and replays the queue after a fixed latency. Stalls come from a pseudo-random sequence, and write-stream gaps come from the same sequence. Request pulses are driven only one cycle wide, so every pulse either starts an access or falls under R8/R9.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HEAD,
        ST_WR_BODY,
        ST_RD_ISSUE,
        ST_RD_HOLD,
        ST_RD_DRAIN
    } mbs_state_t;

endpackage

// File: rtl/mbs_len_calc.sv
// Burst length for the next burst: the smaller of the cap and the words left.
// CNT_W must be at least LEN_W.
module mbs_len_calc #(
    parameter int CNT_W     = 16,
    parameter int MAX_BURST = 8,
    parameter int LEN_W     = 4
) (
    input  logic [CNT_W-1:0] remain,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        if (remain >= CNT_W'(MAX_BURST)) begin
            len = LEN_W'(MAX_BURST);
        end else begin
            len = remain[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/mbs_rd_credit.sv
// Counts read words requested but not yet returned and grants room for the next burst.
module mbs_rd_credit #(
    parameter int MAX_BURST = 8,
    parameter int MAX_OUT   = 1,
    parameter int LEN_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [LEN_W-1:0] issue_len,
    input  logic             ret_valid,
    input  logic [LEN_W-1:0] next_len,
    output logic             room,
    output logic             empty
);
    localparam int LIMIT  = MAX_OUT * MAX_BURST;
    localparam int PEND_W = $clog2(LIMIT + 1);
    localparam int SUM_W  = ((PEND_W > LEN_W) ? PEND_W : LEN_W) + 1;

    logic [PEND_W-1:0] pend_q;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        sum   = SUM_W'(pend_q) + SUM_W'(next_len);
        room  = (sum <= SUM_W'(LIMIT));
        empty = (pend_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + (issue ? PEND_W'(issue_len) : '0) - (ret_valid ? PEND_W'(1) : '0);
        end
    end
endmodule

// File: rtl/mem_burst_seq.sv
module mem_burst_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 8,
    parameter int MAX_OUT   = 1,
    localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_en,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              done,
    input  logic              wr_in_valid,
    input  logic [DATA_W-1:0] wr_in_data,
    output logic              wr_in_ready,
    output logic              rd_out_valid,
    output logic [DATA_W-1:0] rd_out_data,
    input  logic              rd_out_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_burst_len,
    output logic              mem_burst_begin,
    output logic              mem_write,
    output logic              mem_read,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_waitreq,
    input  logic              mem_rdvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    mbs_state_t        state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [ADDR_W-1:0] burst_addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [LEN_W-1:0]  burst_len_q;
    logic [LEN_W-1:0]  beats_q;
    logic [LEN_W-1:0]  next_len;
    logic              credit_room;
    logic              credit_empty;
    logic              start;
    logic              wr_accept;
    logic              rd_accept;
    logic              last_cmd;

    mbs_len_calc #(
        .CNT_W     (CNT_W),
        .MAX_BURST (MAX_BURST),
        .LEN_W     (LEN_W)
    ) u_len (
        .remain (remain_q),
        .len    (next_len)
    );

    mbs_rd_credit #(
        .MAX_BURST (MAX_BURST),
        .MAX_OUT   (MAX_OUT),
        .LEN_W     (LEN_W)
    ) u_credit (
        .clk       (clk),
        .rst       (rst),
        .issue     (rd_accept),
        .issue_len (next_len),
        .ret_valid (mem_rdvalid),
        .next_len  (next_len),
        .room      (credit_room),
        .empty     (credit_empty)
    );

    assign start     = (state_q == ST_IDLE) && req_en && (req_count != '0);
    assign wr_accept = mem_write && !mem_waitreq;
    assign rd_accept = mem_read && !mem_waitreq;
    assign last_cmd  = (remain_q == CNT_W'(next_len));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = req_write ? ST_WR_HEAD : ST_RD_ISSUE;
                end
            end
            ST_WR_HEAD: begin
                if (wr_accept) begin
                    if (next_len == LEN_W'(1)) begin
                        state_d = last_cmd ? ST_IDLE : ST_WR_HEAD;
                    end else begin
                        state_d = ST_WR_BODY;
                    end
                end
            end
            ST_WR_BODY: begin
                if (wr_accept && (beats_q == LEN_W'(1))) begin
                    state_d = (remain_q == '0) ? ST_IDLE : ST_WR_HEAD;
                end
            end
            ST_RD_ISSUE: begin
                if (rd_accept) begin
                    state_d = last_cmd ? ST_RD_DRAIN : ST_RD_ISSUE;
                end else if (mem_read) begin
                    state_d = ST_RD_HOLD;
                end
            end
            ST_RD_HOLD: begin
                if (rd_accept) begin
                    state_d = last_cmd ? ST_RD_DRAIN : ST_RD_ISSUE;
                end
            end
            ST_RD_DRAIN: begin
                if (credit_empty) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and progress registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cur_addr_q   <= '0;
            burst_addr_q <= '0;
            remain_q     <= '0;
            burst_len_q  <= '0;
            beats_q      <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr_q <= req_addr;
                        remain_q   <= req_count;
                    end
                end
                ST_WR_HEAD: begin
                    if (wr_accept) begin
                        burst_addr_q <= cur_addr_q;
                        burst_len_q  <= next_len;
                        cur_addr_q   <= cur_addr_q + ADDR_W'(next_len);
                        remain_q     <= remain_q - CNT_W'(next_len);
                        beats_q      <= next_len - LEN_W'(1);
                    end
                end
                ST_WR_BODY: begin
                    if (wr_accept) begin
                        beats_q <= beats_q - LEN_W'(1);
                    end
                end
                ST_RD_ISSUE, ST_RD_HOLD: begin
                    if (rd_accept) begin
                        cur_addr_q <= cur_addr_q + ADDR_W'(next_len);
                        remain_q   <= remain_q - CNT_W'(next_len);
                    end
                end
                ST_RD_DRAIN: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        done            = 1'b0;
        wr_in_ready     = 1'b0;
        mem_write       = 1'b0;
        mem_read        = 1'b0;
        mem_burst_begin = 1'b0;
        mem_addr        = cur_addr_q;
        mem_burst_len   = next_len;
        unique case (state_q)
            ST_IDLE: begin
                done = 1'b1;
            end
            ST_WR_HEAD: begin
                mem_write       = wr_in_valid;
                mem_burst_begin = wr_in_valid;
                wr_in_ready     = !mem_waitreq;
            end
            ST_WR_BODY: begin
                mem_write     = wr_in_valid;
                wr_in_ready   = !mem_waitreq;
                mem_addr      = burst_addr_q;
                mem_burst_len = burst_len_q;
            end
            ST_RD_ISSUE: begin
                mem_read        = rd_out_ready && credit_room;
                mem_burst_begin = rd_out_ready && credit_room;
            end
            ST_RD_HOLD: begin
                mem_read        = 1'b1;
                mem_burst_begin = 1'b1;
            end
            ST_RD_DRAIN: begin
            end
            default: begin
            end
        endcase
    end

    assign mem_wdata    = wr_in_data;
    assign rd_out_valid = mem_rdvalid;
    assign rd_out_data  = mem_rdata;

endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 32,
    parameter int MAX_BURST = 8,
    parameter int MAX_OUT   = 1,
    parameter int LEN_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_en,
    input logic [CNT_W-1:0]  req_count,
    input logic              done,
    input logic              wr_in_valid,
    input logic [DATA_W-1:0] wr_in_data,
    input logic              wr_in_ready,
    input logic              rd_out_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LEN_W-1:0]  mem_burst_len,
    input logic              mem_burst_begin,
    input logic              mem_write,
    input logic              mem_read,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_waitreq,
    input logic              mem_rdvalid
);
    localparam int LIMIT = MAX_OUT * MAX_BURST;

    logic [15:0] inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_q + ((mem_read && !mem_waitreq) ? 16'(mem_burst_len) : 16'd0)
                                     - (mem_rdvalid ? 16'd1 : 16'd0);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (done && !mem_write && !mem_read));

    // R2
    start_drops_done_chk: assert property (@(posedge clk) disable iff (rst)
        (req_en && done && (req_count != '0)) |=> !done);

    // R9
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (req_en && done && (req_count == '0)) |=> done);

    // R3
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_write && !mem_read));

    // R5
    write_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> wr_in_valid);

    // R5
    take_only_unstalled_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_in_valid && wr_in_ready) |-> (mem_write && !mem_waitreq && (mem_wdata == wr_in_data)));

    // R6
    read_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_read) |-> rd_out_ready);

    // R6
    inflight_cap_chk: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= 16'(LIMIT));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_read && mem_waitreq) |=> (mem_read && $stable(mem_addr) && $stable(mem_burst_len)));

    // R11
    begin_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        mem_burst_begin |-> (mem_read || mem_write));

    // R11
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_read || mem_burst_begin) |-> ((mem_burst_len != '0) && (mem_burst_len <= LEN_W'(MAX_BURST))));

endmodule

bind mem_burst_seq mbs_chk #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .MAX_BURST (MAX_BURST),
    .MAX_OUT   (MAX_OUT),
    .LEN_W     (LEN_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_en          (req_en),
    .req_count       (req_count),
    .done            (done),
    .wr_in_valid     (wr_in_valid),
    .wr_in_data      (wr_in_data),
    .wr_in_ready     (wr_in_ready),
    .rd_out_ready    (rd_out_ready),
    .mem_addr        (mem_addr),
    .mem_burst_len   (mem_burst_len),
    .mem_burst_begin (mem_burst_begin),
    .mem_write       (mem_write),
    .mem_read        (mem_read),
    .mem_wdata       (mem_wdata),
    .mem_waitreq     (mem_waitreq),
    .mem_rdvalid     (mem_rdvalid)
);

// File: tb/sim_mem_burst_seq.sv
module sim_mem_burst_seq;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int DW = 16;
    localparam int MB = 4;
    localparam int MO = 1;
    localparam int LW = $clog2(MB + 1);
    localparam int RD_LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_en = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_count = '0;
    logic done;
    logic wr_in_valid = 1'b0;
    logic [DW-1:0] wr_in_data = '0;
    logic wr_in_ready;
    logic rd_out_valid;
    logic [DW-1:0] rd_out_data;
    logic rd_out_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_burst_len;
    logic mem_burst_begin, mem_write, mem_read;
    logic [DW-1:0] mem_wdata;
    logic mem_waitreq = 1'b0;
    logic mem_rdvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #10ns clk = ~clk;

    mem_burst_seq #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW), .MAX_BURST(MB), .MAX_OUT(MO)) u0 (
        .clk(clk), .rst(rst), .req_en(req_en), .req_write(req_write), .req_addr(req_addr),
        .req_count(req_count), .done(done), .wr_in_valid(wr_in_valid), .wr_in_data(wr_in_data),
        .wr_in_ready(wr_in_ready), .rd_out_valid(rd_out_valid), .rd_out_data(rd_out_data),
        .rd_out_ready(rd_out_ready), .mem_addr(mem_addr), .mem_burst_len(mem_burst_len),
        .mem_burst_begin(mem_burst_begin), .mem_write(mem_write), .mem_read(mem_read),
        .mem_wdata(mem_wdata), .mem_waitreq(mem_waitreq), .mem_rdvalid(mem_rdvalid),
        .mem_rdata(mem_rdata)
    );

    int check_n = 0;
    int fail_n  = 0;

    // environment state
    logic [DW-1:0] mem_arr [0:255];
    logic [15:0] lfsr = 16'hACE1;
    logic stall_en = 1'b0;
    logic gap_en = 1'b0;
    logic preload = 1'b0;
    logic src_on = 1'b0;
    int src_idx = 0, src_total = 0, src_base = 0;
    int cyc = 0;
    int q_addr[$];
    int q_time[$];
    logic [AW-1:0] wptr = '0;
    logic hold_prev = 1'b0;
    int exp_addr = 0, exp_rem = 0, exp_len = 0;
    int burst_errs = 0, bursts = 0, wr_words = 0, rd_cmds = 0;
    int ready_errs = 0, pass_errs = 0, pend = 0, pend_max = 0;
    int rd_n = 0;
    logic [DW-1:0] rd_got [0:255];
    logic [AW-1:0] a;
    int nidx;

    // behavioural controller, write source and monitors
    always @(posedge clk) begin
        cyc = cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_waitreq <= stall_en && (lfsr[1:0] == 2'b00);
        if (preload) begin
            for (int i = 0; i < 256; i++) mem_arr[i] <= DW'(i * 3 + 7);
        end
        if (mem_write && !mem_waitreq) begin
            a = mem_burst_begin ? mem_addr : wptr;
            mem_arr[a] <= mem_wdata;
            wptr <= a + 1'b1;
            wr_words = wr_words + 1;
        end
        if (((mem_write && mem_burst_begin) || mem_read) && !mem_waitreq) begin
            exp_len = (exp_rem > MB) ? MB : exp_rem;
            if (int'(mem_addr) != (exp_addr & 255) || int'(mem_burst_len) != exp_len) burst_errs = burst_errs + 1;
            exp_addr = exp_addr + exp_len;
            exp_rem  = exp_rem - exp_len;
            bursts   = bursts + 1;
        end
        if (mem_read && !mem_waitreq) begin
            rd_cmds = rd_cmds + 1;
            for (int i = 0; i < int'(mem_burst_len); i++) begin
                q_addr.push_back((int'(mem_addr) + i) & 255);
                q_time.push_back(cyc + RD_LAT);
            end
            pend = pend + int'(mem_burst_len);
        end
        if (mem_read && !rd_out_ready && !hold_prev) ready_errs = ready_errs + 1;
        hold_prev <= mem_read && mem_waitreq;
        if (rd_out_valid !== mem_rdvalid || rd_out_data !== mem_rdata) pass_errs = pass_errs + 1;
        if (rd_out_valid) begin
            rd_got[rd_n & 255] = rd_out_data;
            rd_n = rd_n + 1;
            pend = pend - 1;
        end
        if (pend > pend_max) pend_max = pend;
        if (q_addr.size() > 0 && q_time[0] <= cyc) begin
            mem_rdvalid <= 1'b1;
            mem_rdata   <= mem_arr[q_addr[0]];
            void'(q_addr.pop_front());
            void'(q_time.pop_front());
        end else begin
            mem_rdvalid <= 1'b0;
        end
        if (src_on) begin
            nidx = src_idx + ((wr_in_valid && wr_in_ready) ? 1 : 0);
            src_idx <= nidx;
            wr_in_valid <= (nidx < src_total) && (!gap_en || lfsr[2]);
            wr_in_data  <= DW'(src_base + nidx);
        end else begin
            wr_in_valid <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        check_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic clear_stats();
        burst_errs = 0; bursts = 0; wr_words = 0; rd_cmds = 0;
        ready_errs = 0; pass_errs = 0; pend_max = 0; rd_n = 0;
    endtask

    task automatic pulse(input bit wr, input int addr, input int cnt);
        @(posedge clk); #1ns;
        req_en = 1'b1; req_write = wr; req_addr = AW'(addr); req_count = CW'(cnt);
        @(posedge clk); #1ns;
        req_en = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        @(negedge clk);
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, tag, n, 2000);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1ns rst = 1'b0;
        @(negedge clk);
        // R1
        chk(done === 1'b1 && !mem_write && !mem_read, "R1 reset idle", int'(done), 1);
    endtask

    task automatic t_write(input int addr, input int cnt, input bit stall, input bit gap);
        int bad = 0;
        clear_stats();
        stall_en = stall; gap_en = gap;
        exp_addr = addr; exp_rem = cnt;
        src_base = addr * 5 + 1; src_total = cnt; src_idx = 0; src_on = 1'b1;
        pulse(1'b1, addr, cnt);
        // R2
        chk(done === 1'b0, "R2 done falls", int'(done), 0);
        wait_done("R3 write completes");
        src_on = 1'b0;
        for (int i = 0; i < cnt; i++)
            if (mem_arr[(addr + i) & 255] !== DW'(src_base + i)) bad++;
        // R5
        chk(bad == 0, "R5 write data order", bad, 0);
        // R4
        chk(burst_errs == 0 && exp_rem == 0, "R4 write bursts", burst_errs, 0);
        chk(wr_words == cnt, "R4 write word count", wr_words, cnt);
    endtask

    task automatic t_read(input int addr, input int cnt, input bit stall, input bit hold_ready);
        int bad = 0;
        clear_stats();
        stall_en = stall;
        exp_addr = addr; exp_rem = cnt;
        if (hold_ready) rd_out_ready = 1'b0;
        pulse(1'b0, addr, cnt);
        chk(done === 1'b0, "R2 done falls on read", int'(done), 0);
        if (hold_ready) begin
            repeat (20) @(posedge clk);
            #1ns;
            // R6
            chk(rd_cmds == 0 && done === 1'b0, "R6 no read without room", rd_cmds, 0);
            rd_out_ready = 1'b1;
        end
        wait_done("R3 read completes");
        for (int i = 0; i < cnt; i++)
            if (rd_got[i & 255] !== DW'(((addr + i) & 255) * 3 + 7)) bad++;
        // R7
        chk(rd_n == cnt && bad == 0, "R7 read stream", bad + (rd_n - cnt), 0);
        chk(pass_errs == 0, "R7 same cycle forward", pass_errs, 0);
        // R6
        chk(pend_max <= MO * MB && ready_errs == 0, "R6 in-flight cap", pend_max, MO * MB);
        // R4
        chk(burst_errs == 0 && exp_rem == 0, "R4 read bursts", burst_errs, 0);
    endtask

    task automatic t_quiet_after_done();
        clear_stats();
        repeat (6) @(negedge clk);
        // R3
        chk(done === 1'b1 && bursts == 0 && wr_words == 0, "R3 stays done", bursts + wr_words, 0);
    endtask

    task automatic t_zero();
        clear_stats();
        pulse(1'b1, 40, 0);
        @(negedge clk);
        // R9
        chk(done === 1'b1, "R9 zero count done", int'(done), 1);
        repeat (5) @(negedge clk);
        chk(bursts == 0 && wr_words == 0, "R9 zero count quiet", bursts + wr_words, 0);
    endtask

    task automatic t_busy_ignore();
        clear_stats();
        stall_en = 1'b1; gap_en = 1'b1;
        exp_addr = 100; exp_rem = 10;
        src_base = 9; src_total = 10; src_idx = 0; src_on = 1'b1;
        pulse(1'b1, 100, 10);
        repeat (2) @(posedge clk);
        pulse(1'b0, 200, 3);
        wait_done("R8 first access completes");
        src_on = 1'b0;
        repeat (10) @(negedge clk);
        // R8
        chk(rd_cmds == 0 && wr_words == 10 && burst_errs == 0, "R8 busy pulse ignored",
            rd_cmds * 100 + wr_words, 10);
        chk(done === 1'b1, "R8 idle afterwards", int'(done), 1);
    endtask

    initial begin
        #2ms;
        fail_n++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", check_n, fail_n);
        $finish;
    end

    initial begin
        t_reset();
        @(posedge clk); #1ns preload = 1'b1;
        @(posedge clk); #1ns preload = 1'b0;
        t_write(16, 8, 1'b0, 1'b0);
        t_write(250, 10, 1'b1, 1'b1);
        t_write(3, 1, 1'b0, 1'b0);
        t_write(60, 3, 1'b1, 1'b0);
        t_quiet_after_done();
        @(posedge clk); #1ns preload = 1'b1;
        @(posedge clk); #1ns preload = 1'b0;
        t_read(20, 9, 1'b0, 1'b0);
        t_read(130, 4, 1'b1, 1'b0);
        t_read(254, 1, 1'b0, 1'b0);
        t_read(70, 11, 1'b1, 1'b1);
        t_zero();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", check_n, fail_n);
        $finish;
    end
endmodule